// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is an 18-bit first-in first-out buffer. One clock domain writes into it and a second, independent clock domain reads from it. The two clocks may be unrelated, or they may be the same clock. The storage depth is a parameter that must be a power of two; its default is 1024 words. Each pointer crosses into the other domain as a Gray code through a chain of synchronizer flops. As a result every status flag is conservative: it asserts at once in its own domain and releases only after the other pointer has been synchronized.

All five status outputs are active low:
- empty and almost-empty are produced in the read domain.
- full, half-full and almost-full are produced in the write domain.
- The almost-empty and almost-full thresholds are taken from two 12-bit offset inputs, which may change while the buffer is idle.

The read data path ends in a register. Every word, including the first word written into an empty buffer, appears only after an enabled read edge. An output-enable input floats the data pins. A load input, when low, blocks buffer traffic in both domains.

Top module: `dcf_fifo`

## Requirements
- R1: While `rst_n` is low, both pointers are cleared on their clock edges. `full_n`, `half_n` and `afull_n` go high, `empty_n` and `aempty_n` go low, and the read data register becomes zero.
- R2: On a `wr_clk` rising edge with `wr_en_n` low, `load_n` high and `full_n` high, `din` is stored. While `full_n` is low, a write request changes nothing.
- R3: On a `rd_clk` rising edge with `rd_en_n` low, `load_n` high and `empty_n` high, the oldest stored word moves into the read data register. While `empty_n` is low, a read request changes nothing.
- R4: The read data register keeps its value on every `rd_clk` edge that does not perform a read.
- R5: With `oe_n` high, `dout` is high-impedance. With `oe_n` low, `dout` shows the read data register.
- R6: Words leave in the order they were accepted, with none lost or duplicated.
- R7: `empty_n`, updated on `rd_clk`, is low exactly when the level seen by the read side is zero. It returns high only after a written word has been synchronized.
- R8: `full_n`, updated on `wr_clk`, is low when the level seen by the write side equals the depth. It returns high after a read has been synchronized.
- R9: `half_n` is low when the level is strictly greater than half the depth.
- R10: `aempty_n` is low when the level is less than or equal to `ae_off`. An offset at or beyond the depth therefore holds the flag low.
- R11: `afull_n` is low when the level plus `af_off` is greater than or equal to the depth.
- R12: While `load_n` is low, write and read requests are both ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, sampled on each clock |
| load_n | input | 1 | Low blocks all buffer traffic |
| wr_en_n | input | 1 | Active-low write request |
| din | input | 18 | Write data |
| rd_en_n | input | 1 | Active-low read request |
| oe_n | input | 1 | Active-low output enable |
| ae_off | input | 12 | Almost-empty threshold |
| af_off | input | 12 | Almost-full distance from the depth |
| dout | output | 18 | Registered read data, tri-stated |
| empty_n | output | 1 | Low when empty |
| aempty_n | output | 1 | Low when at or below the almost-empty threshold |
| half_n | output | 1 | Low when above half the depth |
| afull_n | output | 1 | Low when within the almost-full distance of the depth |
| full_n | output | 1 | Low when full |

## Verification
Directed sequences cover several cases:
- A single word, which shows that the registered output needs an explicit read.
- Requests made while load is low, which must leave both the flags and the held output unchanged.
- Writes continued past full, which must be dropped without corrupting the ordered drain that follows.
- A fill that stops one word below and one word above each threshold, which pins every flag comparison to its exact edge.

Randomly timed reads and writes on two clocks with unrelated periods then run in write-heavy, read-heavy and balanced phases. These phases drive the pointers through full, through empty and through many Gray-code crossings, with every word compared against a reference queue. A reset applied while the buffer holds data shows that flags and output return to their initial state regardless of the level.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

    localparam int DATA_W_DEF  = 18;
    localparam int OFF_W       = 12;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic full_n;
        logic half_n;
        logic afull_n;
    } wflags_t;

    typedef struct packed {
        logic empty_n;
        logic aempty_n;
    } rflags_t;

    localparam wflags_t WFLAGS_RST = '{full_n: 1'b1, half_n: 1'b1, afull_n: 1'b1};
    localparam rflags_t RFLAGS_RST = '{empty_n: 1'b0, aempty_n: 1'b0};

endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
`timescale 1ns/1ps
module dcf_mem #(
    parameter  int DEPTH  = 1024,
    parameter  int DATA_W = 18,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (re) begin
            q <= store[raddr];
        end
    end
endmodule

// File: rtl/dcf_wr_ctrl.sv
`timescale 1ns/1ps
module dcf_wr_ctrl import dcf_pkg::*; #(
    parameter  int DEPTH = 1024,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [PW-1:0]    rgray_s,
    input  logic [OFF_W-1:0] af_off,
    output logic             wr_fire,
    output logic [AW-1:0]    waddr,
    output logic [PW-1:0]    wgray,
    output wflags_t          flags
);
    localparam int CW = ((PW > OFF_W) ? PW : OFF_W) + 1;

    logic [PW-1:0] wbin, wbin_nx, rbin_s, cnt_nx;
    logic [CW-1:0] cnt_x, off_x;
    wflags_t       fl_q, fl_nx;

    assign wr_fire = wr_req && fl_q.full_n;
    assign wbin_nx = wbin + PW'(wr_fire);

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            rbin_s[i] = ^(rgray_s >> i);
        end
    end

    assign cnt_nx = wbin_nx - rbin_s;
    assign cnt_x  = CW'(cnt_nx);
    assign off_x  = CW'(af_off);

    always_comb begin
        fl_nx.full_n  = (cnt_x != CW'(DEPTH));
        fl_nx.half_n  = !(cnt_x > CW'(DEPTH / 2));
        fl_nx.afull_n = !((cnt_x + off_x) >= CW'(DEPTH));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            fl_q  <= WFLAGS_RST;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
            fl_q  <= fl_nx;
        end
    end

    assign waddr = wbin[AW-1:0];
    assign flags = fl_q;

    a_r2_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_q.full_n |=> $stable(wbin));
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wbin != $past(wbin)) |-> (wbin == $past(wbin) + PW'(1)));
    a_r8_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_x <= CW'(DEPTH));
    a_r9_full_implies_half: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_q.full_n |-> !fl_q.half_n);
    a_r11_full_implies_afull: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_q.full_n |-> !fl_q.afull_n);
endmodule

// File: rtl/dcf_rd_ctrl.sv
`timescale 1ns/1ps
module dcf_rd_ctrl import dcf_pkg::*; #(
    parameter  int DEPTH = 1024,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [PW-1:0]    wgray_s,
    input  logic [OFF_W-1:0] ae_off,
    output logic             rd_fire,
    output logic [AW-1:0]    raddr,
    output logic [PW-1:0]    rgray,
    output rflags_t          flags
);
    localparam int CW = ((PW > OFF_W) ? PW : OFF_W) + 1;

    logic [PW-1:0] rbin, rbin_nx, wbin_s, cnt_nx;
    logic [CW-1:0] cnt_x, off_x;
    rflags_t       fl_q, fl_nx;

    assign rd_fire = rd_req && fl_q.empty_n;
    assign rbin_nx = rbin + PW'(rd_fire);

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            wbin_s[i] = ^(wgray_s >> i);
        end
    end

    assign cnt_nx = wbin_s - rbin_nx;
    assign cnt_x  = CW'(cnt_nx);
    assign off_x  = CW'(ae_off);

    always_comb begin
        fl_nx.empty_n  = (cnt_x != '0);
        fl_nx.aempty_n = !(cnt_x <= off_x);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            fl_q  <= RFLAGS_RST;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
            fl_q  <= fl_nx;
        end
    end

    assign raddr = rbin[AW-1:0];
    assign flags = fl_q;

    a_r3_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_q.empty_n |=> $stable(rbin));
    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rbin != $past(rbin)) |-> (rbin == $past(rbin) + PW'(1)));
    a_r7_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_x <= CW'(DEPTH));
    a_r10_empty_implies_aempty: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_q.empty_n |-> !fl_q.aempty_n);
endmodule

// File: rtl/dcf_fifo.sv
`timescale 1ns/1ps
module dcf_fifo import dcf_pkg::*; #(
    parameter  int DEPTH  = 1024,
    parameter  int DATA_W = DATA_W_DEF,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_en_n,
    input  logic              oe_n,
    input  logic [OFF_W-1:0]  ae_off,
    input  logic [OFF_W-1:0]  af_off,
    output logic [DATA_W-1:0] dout,
    output logic              empty_n,
    output logic              aempty_n,
    output logic              half_n,
    output logic              afull_n,
    output logic              full_n
);
    logic              wr_req, rd_req, wr_fire, rd_fire;
    logic [AW-1:0]     waddr, raddr;
    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
    logic [DATA_W-1:0] rdata_q;
    wflags_t           wfl;
    rflags_t           rfl;

    assign wr_req = !wr_en_n && load_n;
    assign rd_req = !rd_en_n && load_n;

    dcf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_req(wr_req), .rgray_s(rgray_s),
        .af_off(af_off), .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray), .flags(wfl)
    );

    dcf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .rd_req(rd_req), .wgray_s(wgray_s),
        .ae_off(ae_off), .rd_fire(rd_fire), .raddr(raddr), .rgray(rgray), .flags(rfl)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    dcf_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .wr_clk(wr_clk), .we(wr_fire), .waddr(waddr), .wdata(din),
        .rd_clk(rd_clk), .rst_n(rst_n), .re(rd_fire), .raddr(raddr), .q(rdata_q)
    );

    assign dout     = oe_n ? {DATA_W{1'bz}} : rdata_q;
    assign empty_n  = rfl.empty_n;
    assign aempty_n = rfl.aempty_n;
    assign half_n   = wfl.half_n;
    assign afull_n  = wfl.afull_n;
    assign full_n   = wfl.full_n;

    a_r4_hold_without_read: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en_n || !load_n) |=> $stable(rdata_q));
    a_r12_load_blocks_write: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !load_n |-> !wr_fire);
endmodule

// File: tb/dcf_fifo_tb.sv
`timescale 1ns/1ps
module dcf_fifo_tb;
    localparam int DEPTH = 1024;
    localparam int DW    = 18;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          rst_n, load_n, wr_en_n, rd_en_n, oe_n;
    logic [DW-1:0] din;
    logic [11:0]   ae_off, af_off;
    wire  [DW-1:0] dout_w;
    logic          empty_n, aempty_n, half_n, afull_n, full_n;

    for (genvar i = 0; i < DW; i++) begin : g_pu
        pullup (dout_w[i]);
    end

    always #2 wr_clk = ~wr_clk;
    always #3 rd_clk = ~rd_clk;

    dcf_fifo u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .load_n(load_n),
        .wr_en_n(wr_en_n), .din(din), .rd_en_n(rd_en_n), .oe_n(oe_n),
        .ae_off(ae_off), .af_off(af_off), .dout(dout_w), .empty_n(empty_n),
        .aempty_n(aempty_n), .half_n(half_n), .afull_n(afull_n), .full_n(full_n)
    );

    int            n_cmp = 0, n_bad = 0, popped = 0;
    bit            done = 1'b0, pend = 1'b0;
    logic [DW-1:0] pend_val, last_rd;
    logic [DW-1:0] mq[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit x_empty_n(int n);  return n != 0;                 endfunction
    function automatic bit x_full_n(int n);   return n != DEPTH;             endfunction
    function automatic bit x_half_n(int n);   return !(n > DEPTH / 2);       endfunction
    function automatic bit x_aempty_n(int n, int ae); return !(n <= ae);     endfunction
    function automatic bit x_afull_n(int n, int af);  return !(n + af >= DEPTH); endfunction

    task automatic chk_flags(input string tag);
        int n = mq.size();
        chk(empty_n  == x_empty_n(n),  {tag, " R7 empty_n"},  32'(empty_n),  32'(x_empty_n(n)));
        chk(full_n   == x_full_n(n),   {tag, " R8 full_n"},   32'(full_n),   32'(x_full_n(n)));
        chk(half_n   == x_half_n(n),   {tag, " R9 half_n"},   32'(half_n),   32'(x_half_n(n)));
        chk(aempty_n == x_aempty_n(n, int'(ae_off)), {tag, " R10 aempty_n"}, 32'(aempty_n),
            32'(x_aempty_n(n, int'(ae_off))));
        chk(afull_n  == x_afull_n(n, int'(af_off)),  {tag, " R11 afull_n"},  32'(afull_n),
            32'(x_afull_n(n, int'(af_off))));
    endtask

    task automatic wr_cycle(input bit en);
        @(negedge wr_clk);
        wr_en_n = !en;
        din     = DW'($urandom);
        if (en && load_n && full_n) mq.push_back(din);
    endtask

    task automatic rd_cycle(input bit en);
        @(negedge rd_clk);
        if (pend) begin
            chk(dout_w == pend_val, "R3/R6 read data", 32'(dout_w), 32'(pend_val));
            last_rd = pend_val;
            pend    = 1'b0;
        end
        rd_en_n = !en;
        if (en && load_n && empty_n && mq.size() > 0) begin
            pend_val = mq.pop_front();
            pend     = 1'b1;
            popped++;
        end
    endtask

    task automatic settle();
        fork
            begin @(negedge wr_clk); wr_en_n = 1'b1; end
            begin repeat (10) rd_cycle(1'b0); end
        join
    endtask

    task automatic fill_to(input int lvl);
        while (mq.size() < lvl) wr_cycle(1'b1);
        settle();
    endtask

    task automatic do_reset();
        @(negedge wr_clk);
        rst_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1;
        repeat (6) @(negedge rd_clk);
        @(negedge wr_clk);
        rst_n = 1'b1;
        mq.delete(); pend = 1'b0; last_rd = '0;
        repeat (2) @(negedge rd_clk);
    endtask

    task automatic rand_phase(input int pw, input int pr);
        fork
            begin repeat (1500) wr_cycle($urandom_range(99) < pw); end
            begin repeat (1000) rd_cycle($urandom_range(99) < pr); end
        join
        settle();
        chk_flags("random phase");
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; load_n = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1; oe_n = 1'b0;
        din = '0; ae_off = 12'd100; af_off = 12'd200; last_rd = '0; pend_val = '0;
        do_reset();

        // R1 reset state
        chk_flags("R1 after reset");
        chk(dout_w == '0, "R1 output register zero", 32'(dout_w), 0);
        // R5 tri-state versus driven
        @(negedge rd_clk); oe_n = 1'b1; #1;
        chk(dout_w == '1, "R5 oe_n high floats dout", 32'(dout_w), 32'h3ffff);
        oe_n = 1'b0; #1;
        chk(dout_w == '0, "R5 oe_n low drives register", 32'(dout_w), 0);

        // R3 read while empty is ignored
        repeat (4) rd_cycle(1'b1);
        settle();
        chk(dout_w == '0, "R3 read while empty ignored", 32'(dout_w), 0);
        chk_flags("R3 empty read");

        // single word: needs explicit read
        wr_cycle(1'b1);
        settle();
        chk_flags("R7 one word");
        chk(dout_w == '0, "R4 no read yet, dout held", 32'(dout_w), 0);
        rd_cycle(1'b1);
        settle();
        chk_flags("R7 after last read");

        // R12 load low blocks both sides
        @(negedge wr_clk); load_n = 1'b0;
        repeat (4) wr_cycle(1'b1);
        settle();
        chk_flags("R12 write with load low");
        @(negedge wr_clk); load_n = 1'b1;
        repeat (3) wr_cycle(1'b1);
        settle();
        @(negedge wr_clk); load_n = 1'b0;
        repeat (4) rd_cycle(1'b1);
        settle();
        chk(dout_w == last_rd, "R12/R4 read with load low leaves dout", 32'(dout_w), 32'(last_rd));
        chk_flags("R12 read with load low");
        @(negedge wr_clk); load_n = 1'b1;
        repeat (5) rd_cycle(1'b1);
        settle();
        chk_flags("R12 drained");

        // R2/R8 overfill, then drain in order
        repeat (DEPTH + 5) wr_cycle(1'b1);
        settle();
        chk(mq.size() == DEPTH, "R2 level stops at depth", 32'(mq.size()), DEPTH);
        chk_flags("R8 full");
        rd_cycle(1'b1);
        settle();
        chk_flags("R8 full released after read");
        popped = 0;
        repeat (DEPTH + 10) rd_cycle(1'b1);
        settle();
        chk(popped == DEPTH - 1, "R2/R6 drained word count", 32'(popped), DEPTH - 1);
        chk_flags("R6 drained");

        // threshold boundaries
        begin
            int lv[7] = '{100, 101, 512, 513, 823, 824, 1024};
            foreach (lv[k]) begin
                fill_to(lv[k]);
                chk_flags($sformatf("R9/R10/R11 level %0d", lv[k]));
            end
        end
        @(negedge wr_clk); ae_off = 12'd4095; af_off = 12'd0;
        settle();
        chk_flags("R10 offset beyond depth");

        // reset with content
        do_reset();
        chk_flags("R1 reset with content");
        chk(dout_w == '0, "R1 output cleared by reset", 32'(dout_w), 0);

        // random traffic
        @(negedge wr_clk); ae_off = 12'd30; af_off = 12'd40;
        rand_phase(95, 20);
        rand_phase(10, 95);
        rand_phase(60, 85);
        rand_phase(50, 50);
        popped = 0;
        repeat (DEPTH + 10) rd_cycle(1'b1);
        settle();
        chk_flags("R6 final drain");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule